// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block decides, every cycle, whether a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) may advance. It looks at a small descriptor of the instruction in each stage and drives hold, bubble and kill controls for the stage registers. It also drives forwarding selects for the two execute operands. The datapath, the instruction decoder and the memories sit outside it.

The hold, bubble and kill controls act on the stage registers as follows:
- `stall_if` holds the program counter.
- `stall_id` holds the fetch/decode register.
- `bubble_ex` loads an empty slot into the decode/execute register.
- `kill_if` loads an empty slot into the fetch/decode register, which discards the instruction now in fetch.
- `kill_id` discards the instruction now in decode by emptying the decode/execute register.

A two-bit configuration picks one of four hazard models. The configuration is captured while reset is asserted and stays fixed until the next reset.
- Model 0 has a register file that cannot read and write in the same cycle, plus one memory shared by fetch and data accesses.
- Model 1 keeps the shared memory but has a register file with two read ports and one write port. A write in writeback is visible to decode in the same cycle.
- Model 2 adds separate instruction and data ports.
- Model 3 also forwards results to the execute operands from the memory and writeback stages.

Branches resolve in execute and have no delay slot.

Top module: `hazard_ctl`

## Requirements
- R1: The model is taken from `mode_cfg` on clock edges where `rst_n` is low. Changes of `mode_cfg` while `rst_n` is high have no effect. The encodings are 0 = single-port register file with shared memory, 1 = shared memory, 2 = split memories, 3 = split memories with forwarding.
- R2: In model 0, any cycle with `wb_valid` and `wb_wen` both high drives `stall_if`, `stall_id` and `bubble_ex` to 1, unless a taken branch is in execute. In models 1 to 3, a writeback write alone causes no hold.
- R3: In models 0 to 2, a valid decode instruction holds (`stall_if`, `stall_id` and `bubble_ex` all 1) when it reads a register through a source whose use flag is set, and that register is the destination of a valid, writing instruction in execute or memory. In models 1 and 2, a matching producer in writeback causes no hold. A decode slot with `id_valid` low, or a source with its use flag low, never holds.
- R4: In models 0 and 1, a valid memory-stage instruction with `mem_mread` or `mem_mwrite` set drives `stall_if` to 1. When decode is not held, it also drives `kill_if` to 1 and leaves `stall_id` at 0.
- R5: In models 2 and 3, a memory-stage load or store never holds fetch.
- R6: In model 3, a decode instruction that reads the destination of a load in execute (`ex_mread` set) holds for that cycle with a bubble. A non-load producer in execute, memory or writeback causes no hold.
- R7: In model 3, each of `fwd_a` and `fwd_b` is chosen for the execute-stage source `ex_rs1` or `ex_rs2` respectively, and only while `ex_valid` is high. The code is 2'b10 when the valid, writing memory-stage destination matches, else 2'b01 when the valid, writing writeback destination matches, else 2'b00. The code 2'b11 never appears.
- R8: In models 0 to 2, `fwd_a` and `fwd_b` are always 2'b00.
- R9: A taken branch (`ex_valid` and `ex_br_taken`) drives `kill_if` and `kill_id` to 1 and drives `stall_if`, `stall_id` and `bubble_ex` to 0, whatever other hazard is present.
- R10: Register 0 never causes a hold and never selects forwarding.
- R11: When several hazards coincide, the following all hold:
  - `bubble_ex` and `kill_id` are never both 1.
  - `stall_id` implies `stall_if` and `bubble_ex`.
  - `stall_id` forces `kill_if` to 0.
- R12: While `rst_n` is low, all of `stall_if`, `stall_id`, `bubble_ex`, `kill_if`, `kill_id`, `fwd_a` and `fwd_b` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the model is captured while it is low |
| mode_cfg | input | 2 | Hazard model selection |
| id_valid | input | 1 | Decode slot holds an instruction |
| id_rs1 | input | REG_AW | Decode first source register |
| id_rs1_used | input | 1 | Decode instruction reads its first source |
| id_rs2 | input | REG_AW | Decode second source register |
| id_rs2_used | input | 1 | Decode instruction reads its second source |
| ex_valid | input | 1 | Execute slot holds an instruction |
| ex_rd | input | REG_AW | Execute destination register |
| ex_wen | input | 1 | Execute instruction writes the register file |
| ex_mread | input | 1 | Execute instruction is a load |
| ex_rs1 | input | REG_AW | Execute first source register |
| ex_rs2 | input | REG_AW | Execute second source register |
| ex_br_taken | input | 1 | Branch in execute is taken |
| mem_valid | input | 1 | Memory slot holds an instruction |
| mem_rd | input | REG_AW | Memory-stage destination register |
| mem_wen | input | 1 | Memory-stage instruction writes the register file |
| mem_mread | input | 1 | Memory-stage instruction reads data memory |
| mem_mwrite | input | 1 | Memory-stage instruction writes data memory |
| wb_valid | input | 1 | Writeback slot holds an instruction |
| wb_rd | input | REG_AW | Writeback destination register |
| wb_wen | input | 1 | Writeback instruction writes the register file |
| stall_if | output | 1 | Hold the program counter |
| stall_id | output | 1 | Hold the fetch/decode register |
| bubble_ex | output | 1 | Load an empty slot into execute |
| kill_if | output | 1 | Discard the instruction in fetch |
| kill_id | output | 1 | Discard the instruction in decode |
| fwd_a | output | 2 | Operand A source select |
| fwd_b | output | 2 | Operand B source select |

## Verification
The bound checker checks these relations on every cycle:
- the model stays fixed after reset;
- a taken branch always overrides every hold;
- a bubble and a decode kill never coincide;
- fetch holds whenever decode holds;
- split-memory models never hold fetch alone;
- the register-file port and shared-memory holds are present when their causes are;
- forwarding stays off outside model 3 and never uses the unused code.

Only the directed scenarios show some behaviours:
- which exact producer matches cause a hold in each model, and which do not;
- the load-use case, and register 0 being ignored;
- the priority of the memory-stage match over the writeback match;
- a configuration change after reset being ignored.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

   typedef enum logic [1:0] {
      HZ_RF1P_SHARED = 2'd0,
      HZ_SHARED      = 2'd1,
      HZ_SPLIT       = 2'd2,
      HZ_BYPASS      = 2'd3
   } hz_mode_e;

   typedef enum logic [1:0] {
      FWD_RF  = 2'b00,
      FWD_WB  = 2'b01,
      FWD_MEM = 2'b10
   } fwd_sel_e;

   // producer slots, youngest first
   localparam int PROD_EX  = 0;
   localparam int PROD_MEM = 1;
   localparam int PROD_WB  = 2;
   localparam int NUM_PROD = 3;

   function automatic logic mode_single_rf_port(hz_mode_e m);
      return m == HZ_RF1P_SHARED;
   endfunction

   function automatic logic mode_shared_mem(hz_mode_e m);
      return (m == HZ_RF1P_SHARED) || (m == HZ_SHARED);
   endfunction

   function automatic logic mode_bypass(hz_mode_e m);
      return m == HZ_BYPASS;
   endfunction

endpackage

// File: rtl/hazard_match.sv
module hazard_match #(
   parameter int AW = 5
) (
   input  logic          src_used,
   input  logic [AW-1:0] src,
   input  logic          prod_valid,
   input  logic          prod_wen,
   input  logic [AW-1:0] prod_rd,
   output logic          hit
);
   logic rd_nonzero;

   assign rd_nonzero = |prod_rd;
   assign hit = src_used & prod_valid & prod_wen & rd_nonzero & (prod_rd == src);
endmodule

// File: rtl/hazard_src_scan.sv
module hazard_src_scan #(
   parameter int AW = 5,
   parameter int NP = 3
) (
   input  logic                 src_used,
   input  logic [AW-1:0]        src,
   input  logic [NP-1:0]        p_valid,
   input  logic [NP-1:0]        p_wen,
   input  logic [NP-1:0][AW-1:0] p_rd,
   output logic [NP-1:0]        hit
);
   for (genvar p = 0; p < NP; p++) begin : g_prod
      hazard_match #(.AW(AW)) u_match (
         .src_used   (src_used),
         .src        (src),
         .prod_valid (p_valid[p]),
         .prod_wen   (p_wen[p]),
         .prod_rd    (p_rd[p]),
         .hit        (hit[p])
      );
   end
endmodule

// File: rtl/hazard_fwd_mux.sv
module hazard_fwd_mux
   import hazard_pkg::*;
#(
   parameter int AW = 5
) (
   input  logic          en,
   input  logic          cons_valid,
   input  logic [AW-1:0] src,
   input  logic          mem_valid,
   input  logic          mem_wen,
   input  logic [AW-1:0] mem_rd,
   input  logic          wb_valid,
   input  logic          wb_wen,
   input  logic [AW-1:0] wb_rd,
   output fwd_sel_e      sel
);
   logic look;
   logic hit_mem;
   logic hit_wb;

   assign look = en & cons_valid;

   hazard_match #(.AW(AW)) u_mem (
      .src_used   (look),
      .src        (src),
      .prod_valid (mem_valid),
      .prod_wen   (mem_wen),
      .prod_rd    (mem_rd),
      .hit        (hit_mem)
   );

   hazard_match #(.AW(AW)) u_wb (
      .src_used   (look),
      .src        (src),
      .prod_valid (wb_valid),
      .prod_wen   (wb_wen),
      .prod_rd    (wb_rd),
      .hit        (hit_wb)
   );

   // newer result takes priority
   always_comb begin
      if (hit_mem)     sel = FWD_MEM;
      else if (hit_wb) sel = FWD_WB;
      else             sel = FWD_RF;
   end
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
   import hazard_pkg::*;
#(
   parameter int REG_AW = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_cfg,
   input  logic              id_valid,
   input  logic [REG_AW-1:0] id_rs1,
   input  logic              id_rs1_used,
   input  logic [REG_AW-1:0] id_rs2,
   input  logic              id_rs2_used,
   input  logic              ex_valid,
   input  logic [REG_AW-1:0] ex_rd,
   input  logic              ex_wen,
   input  logic              ex_mread,
   input  logic [REG_AW-1:0] ex_rs1,
   input  logic [REG_AW-1:0] ex_rs2,
   input  logic              ex_br_taken,
   input  logic              mem_valid,
   input  logic [REG_AW-1:0] mem_rd,
   input  logic              mem_wen,
   input  logic              mem_mread,
   input  logic              mem_mwrite,
   input  logic              wb_valid,
   input  logic [REG_AW-1:0] wb_rd,
   input  logic              wb_wen,
   output logic              stall_if,
   output logic              stall_id,
   output logic              bubble_ex,
   output logic              kill_if,
   output logic              kill_id,
   output logic [1:0]        fwd_a,
   output logic [1:0]        fwd_b
);
   localparam int NUM_SRC = 2;

   initial begin
      if (REG_AW < 2 || REG_AW > 8)
         $fatal(1, "hazard_ctl: REG_AW must lie in 2..8");
   end

   // configuration captured while held in reset
   hz_mode_e mode_q;
   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= hz_mode_e'(mode_cfg);
   end

   logic [NUM_PROD-1:0]             p_valid;
   logic [NUM_PROD-1:0]             p_wen;
   logic [NUM_PROD-1:0][REG_AW-1:0] p_rd;

   assign p_valid[PROD_EX]  = ex_valid;
   assign p_valid[PROD_MEM] = mem_valid;
   assign p_valid[PROD_WB]  = wb_valid;
   assign p_wen[PROD_EX]    = ex_wen;
   assign p_wen[PROD_MEM]   = mem_wen;
   assign p_wen[PROD_WB]    = wb_wen;
   assign p_rd[PROD_EX]     = ex_rd;
   assign p_rd[PROD_MEM]    = mem_rd;
   assign p_rd[PROD_WB]     = wb_rd;

   logic [NUM_SRC-1:0][REG_AW-1:0] d_src;
   logic [NUM_SRC-1:0]             d_use;
   logic [NUM_SRC-1:0][NUM_PROD-1:0] d_hit;

   assign d_src = {id_rs2, id_rs1};
   assign d_use = {id_rs2_used, id_rs1_used} & {NUM_SRC{id_valid}};

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      hazard_src_scan #(.AW(REG_AW), .NP(NUM_PROD)) u_scan (
         .src_used (d_use[s]),
         .src      (d_src[s]),
         .p_valid  (p_valid),
         .p_wen    (p_wen),
         .p_rd     (p_rd),
         .hit      (d_hit[s])
      );
   end

   logic any_ex;
   logic any_mem;
   always_comb begin
      any_ex  = 1'b0;
      any_mem = 1'b0;
      for (int s = 0; s < NUM_SRC; s++) begin
         any_ex  = any_ex  | d_hit[s][PROD_EX];
         any_mem = any_mem | d_hit[s][PROD_MEM];
      end
   end

   logic data_hold;
   logic port_hold;
   logic fetch_block;
   logic redirect;
   logic decode_hold;

   always_comb begin
      if (mode_bypass(mode_q)) data_hold = any_ex & ex_mread;
      else                     data_hold = any_ex | any_mem;
   end

   assign port_hold   = mode_single_rf_port(mode_q) & wb_valid & wb_wen;
   assign fetch_block = mode_shared_mem(mode_q) & mem_valid & (mem_mread | mem_mwrite);
   assign redirect    = ex_valid & ex_br_taken;
   assign decode_hold = (data_hold | port_hold) & ~redirect;

   assign stall_id  = rst_n & decode_hold;
   assign bubble_ex = rst_n & decode_hold;
   assign stall_if  = rst_n & ~redirect & (decode_hold | fetch_block);
   assign kill_if   = rst_n & (redirect | (fetch_block & ~decode_hold));
   assign kill_id   = rst_n & redirect;

   // operand forwarding
   logic [NUM_SRC-1:0][REG_AW-1:0] x_src;
   fwd_sel_e                       op_sel [NUM_SRC];
   logic                           fwd_en;

   assign x_src  = {ex_rs2, ex_rs1};
   assign fwd_en = rst_n & mode_bypass(mode_q);

   for (genvar o = 0; o < NUM_SRC; o++) begin : g_op
      hazard_fwd_mux #(.AW(REG_AW)) u_fwd (
         .en         (fwd_en),
         .cons_valid (ex_valid),
         .src        (x_src[o]),
         .mem_valid  (mem_valid),
         .mem_wen    (mem_wen),
         .mem_rd     (mem_rd),
         .wb_valid   (wb_valid),
         .wb_wen     (wb_wen),
         .wb_rd      (wb_rd),
         .sel        (op_sel[o])
      );
   end

   assign fwd_a = op_sel[0];
   assign fwd_b = op_sel[1];
endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode_q,
   input logic       ex_valid,
   input logic       ex_br_taken,
   input logic       mem_valid,
   input logic       mem_mread,
   input logic       mem_mwrite,
   input logic       wb_valid,
   input logic       wb_wen,
   input logic       stall_if,
   input logic       stall_id,
   input logic       bubble_ex,
   input logic       kill_if,
   input logic       kill_id,
   input logic [1:0] fwd_a,
   input logic [1:0] fwd_b
);
   logic redir;
   assign redir = ex_valid & ex_br_taken;

   assert_mode_fixed_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(mode_q));

   assert_port_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'd0 && wb_valid && wb_wen && !redir) |-> (stall_if && stall_id && bubble_ex));

   assert_shared_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q[1] && mem_valid && (mem_mread || mem_mwrite) && !redir) |-> stall_if);

   assert_split_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q[1] |-> (stall_if == stall_id));

   assert_fwd_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_a != 2'b11) && (fwd_b != 2'b11));

   assert_no_fwd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != 2'd3) |-> (fwd_a == 2'b00 && fwd_b == 2'b00));

   assert_redirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
      redir |-> (kill_if && kill_id && !stall_if && !stall_id && !bubble_ex));

   assert_one_bubble_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(bubble_ex && kill_id));

   assert_hold_shape_R11: assert property (@(posedge clk) disable iff (!rst_n)
      stall_id |-> (stall_if && bubble_ex && !kill_if));
endmodule

bind hazard_ctl hazard_ctl_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_q      (mode_q),
   .ex_valid    (ex_valid),
   .ex_br_taken (ex_br_taken),
   .mem_valid   (mem_valid),
   .mem_mread   (mem_mread),
   .mem_mwrite  (mem_mwrite),
   .wb_valid    (wb_valid),
   .wb_wen      (wb_wen),
   .stall_if    (stall_if),
   .stall_id    (stall_id),
   .bubble_ex   (bubble_ex),
   .kill_if     (kill_if),
   .kill_id     (kill_id),
   .fwd_a       (fwd_a),
   .fwd_b       (fwd_b)
);

// File: tb/hazard_ctl_tb.sv
module hazard_ctl_tb;
   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    mode_cfg = 2'd0;
   logic          id_valid, id_rs1_used, id_rs2_used;
   logic [AW-1:0] id_rs1, id_rs2;
   logic          ex_valid, ex_wen, ex_mread, ex_br_taken;
   logic [AW-1:0] ex_rd, ex_rs1, ex_rs2;
   logic          mem_valid, mem_wen, mem_mread, mem_mwrite;
   logic [AW-1:0] mem_rd;
   logic          wb_valid, wb_wen;
   logic [AW-1:0] wb_rd;
   logic          stall_if, stall_id, bubble_ex, kill_if, kill_id;
   logic [1:0]    fwd_a, fwd_b;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   hazard_ctl #(.REG_AW(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg),
      .id_valid(id_valid), .id_rs1(id_rs1), .id_rs1_used(id_rs1_used),
      .id_rs2(id_rs2), .id_rs2_used(id_rs2_used),
      .ex_valid(ex_valid), .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_mread(ex_mread),
      .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_br_taken(ex_br_taken),
      .mem_valid(mem_valid), .mem_rd(mem_rd), .mem_wen(mem_wen),
      .mem_mread(mem_mread), .mem_mwrite(mem_mwrite),
      .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_wen(wb_wen),
      .stall_if(stall_if), .stall_id(stall_id), .bubble_ex(bubble_ex),
      .kill_if(kill_if), .kill_id(kill_id), .fwd_a(fwd_a), .fwd_b(fwd_b)
   );

   // order: stall_if stall_id bubble_ex kill_if kill_id fwd_a fwd_b
   localparam logic [8:0] E_NONE  = 9'b00000_00_00;
   localparam logic [8:0] E_HOLD  = 9'b11100_00_00;
   localparam logic [8:0] E_FETCH = 9'b10010_00_00;
   localparam logic [8:0] E_REDIR = 9'b00011_00_00;

   task automatic idle();
      id_valid = 0; id_rs1 = '0; id_rs1_used = 0; id_rs2 = '0; id_rs2_used = 0;
      ex_valid = 0; ex_rd = '0; ex_wen = 0; ex_mread = 0; ex_rs1 = '0; ex_rs2 = '0;
      ex_br_taken = 0;
      mem_valid = 0; mem_rd = '0; mem_wen = 0; mem_mread = 0; mem_mwrite = 0;
      wb_valid = 0; wb_rd = '0; wb_wen = 0;
   endtask

   task automatic step();
      @(negedge clk);
      idle();
   endtask

   task automatic expect9(input logic [8:0] exp, input string tag);
      logic [8:0] got;
      #1;
      got = {stall_if, stall_id, bubble_ex, kill_if, kill_id, fwd_a, fwd_b};
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%b expected=%b", tag, got, exp);
      end
   endtask

   task automatic boot(input logic [1:0] m);
      @(negedge clk);
      idle();
      rst_n = 0;
      mode_cfg = m;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1;
      mode_cfg = ~m; // later changes must not matter (R1)
   endtask

   task automatic t_reset();
      @(negedge clk);
      idle();
      rst_n = 0; mode_cfg = 2'd0;
      wb_valid = 1; wb_wen = 1; wb_rd = 5'd7;
      mem_valid = 1; mem_mread = 1;
      ex_valid = 1; ex_br_taken = 1;
      expect9(E_NONE, "R12 outputs quiet in reset");
   endtask

   task automatic t_mode0();
      boot(2'd0);
      step(); wb_valid = 1; wb_wen = 1; wb_rd = 5'd7;
      expect9(E_HOLD, "R2 writeback write holds decode");
      step(); id_valid = 1; id_rs1 = 5'd5; id_rs1_used = 1;
      ex_valid = 1; ex_wen = 1; ex_rd = 5'd5;
      expect9(E_HOLD, "R3 execute producer holds");
      step(); id_valid = 1; id_rs1 = 5'd0; id_rs1_used = 1;
      ex_valid = 1; ex_wen = 1; ex_rd = 5'd0;
      expect9(E_NONE, "R10 register 0 no hold");
      step(); mem_valid = 1; mem_mwrite = 1;
      expect9(E_FETCH, "R4 store blocks fetch");
      step(); ex_valid = 1; ex_br_taken = 1; wb_valid = 1; wb_wen = 1; wb_rd = 5'd3;
      expect9(E_REDIR, "R9 branch overrides port hold");
      step(); ex_valid = 1; ex_rs1 = 5'd3; mem_valid = 1; mem_wen = 1; mem_rd = 5'd3;
      expect9(E_NONE, "R8 no forwarding in model 0");
   endtask

   task automatic t_mode1();
      boot(2'd1);
      step(); id_valid = 1; id_rs1 = 5'd9; id_rs1_used = 1;
      wb_valid = 1; wb_wen = 1; wb_rd = 5'd9;
      expect9(E_NONE, "R3 writeback producer no hold (R2 port)");
      step(); id_valid = 1; id_rs1 = 5'd9; id_rs1_used = 1;
      mem_valid = 1; mem_wen = 1; mem_rd = 5'd9;
      expect9(E_HOLD, "R3 memory producer holds");
      step(); id_valid = 1; id_rs1 = 5'd6; id_rs1_used = 1;
      mem_valid = 1; mem_mread = 1; mem_wen = 1; mem_rd = 5'd4;
      expect9(E_FETCH, "R4 load blocks fetch");
      step(); id_valid = 1; id_rs1 = 5'd6; id_rs1_used = 1;
      ex_valid = 1; ex_wen = 1; ex_rd = 5'd6;
      mem_valid = 1; mem_mread = 1; mem_wen = 1; mem_rd = 5'd4;
      expect9(E_HOLD, "R11 combined hold no fetch kill");
      step(); mem_valid = 1; mem_mwrite = 1;
      expect9(E_FETCH, "R1 model kept after config change");
   endtask

   task automatic t_mode2();
      boot(2'd2);
      step(); mem_valid = 1; mem_mwrite = 1;
      expect9(E_NONE, "R5 store leaves fetch free");
      step(); id_valid = 1; id_rs2 = 5'd12; id_rs2_used = 1;
      ex_valid = 1; ex_wen = 1; ex_rd = 5'd12;
      expect9(E_HOLD, "R3 second source holds");
      step(); id_valid = 1; id_rs2 = 5'd12; id_rs2_used = 0;
      ex_valid = 1; ex_wen = 1; ex_rd = 5'd12;
      expect9(E_NONE, "R3 unused source ignored");
      step(); id_valid = 0; id_rs1 = 5'd12; id_rs1_used = 1;
      ex_valid = 1; ex_wen = 1; ex_rd = 5'd12;
      expect9(E_NONE, "R3 empty decode slot ignored");
   endtask

   task automatic t_mode3();
      boot(2'd3);
      step(); wb_valid = 1; wb_wen = 1; wb_rd = 5'd2;
      expect9(E_NONE, "R2 no port hold in model 3 (R1)");
      step(); mem_valid = 1; mem_mread = 1; mem_wen = 1; mem_rd = 5'd8;
      expect9(E_NONE, "R5 load leaves fetch free");
      step(); id_valid = 1; id_rs1 = 5'd8; id_rs1_used = 1;
      ex_valid = 1; ex_wen = 1; ex_rd = 5'd8;
      expect9(E_NONE, "R6 ALU producer no hold");
      step(); id_valid = 1; id_rs1 = 5'd8; id_rs1_used = 1;
      ex_valid = 1; ex_wen = 1; ex_mread = 1; ex_rd = 5'd8;
      expect9(E_HOLD, "R6 load-use hold");
      step(); ex_valid = 1; ex_rs1 = 5'd3; ex_rs2 = 5'd4;
      mem_valid = 1; mem_wen = 1; mem_rd = 5'd3;
      wb_valid = 1; wb_wen = 1; wb_rd = 5'd4;
      expect9(9'b00000_10_01, "R7 memory and writeback selects");
      step(); ex_valid = 1; ex_rs1 = 5'd3; ex_rs2 = 5'd3;
      mem_valid = 1; mem_wen = 1; mem_rd = 5'd3;
      wb_valid = 1; wb_wen = 1; wb_rd = 5'd3;
      expect9(9'b00000_10_10, "R7 newer producer wins");
      step(); ex_valid = 1; ex_rs1 = 5'd0; ex_rs2 = 5'd0;
      mem_valid = 1; mem_wen = 1; mem_rd = 5'd0;
      wb_valid = 1; wb_wen = 1; wb_rd = 5'd0;
      expect9(E_NONE, "R10 register 0 not forwarded");
      step(); ex_valid = 1; ex_rs1 = 5'd3; ex_rs2 = 5'd4;
      mem_valid = 1; mem_wen = 0; mem_rd = 5'd3;
      wb_valid = 1; wb_wen = 1; wb_rd = 5'd3;
      expect9(9'b00000_01_00, "R7 non-writing memory stage skipped");
      step(); ex_valid = 0; ex_rs1 = 5'd3;
      mem_valid = 1; mem_wen = 1; mem_rd = 5'd3;
      expect9(E_NONE, "R7 empty execute slot");
      step(); id_valid = 1; id_rs1 = 5'd8; id_rs1_used = 1;
      ex_valid = 1; ex_wen = 1; ex_mread = 1; ex_rd = 5'd8; ex_br_taken = 1;
      expect9(E_REDIR, "R9 branch beats load-use (R11)");
   endtask

   initial begin
      #(8 * 20000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle();
      t_reset();
      t_mode0();
      t_mode1();
      t_mode2();
      t_mode3();
      step();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule